// File: doc/BRIEF.md
# Configurable Serial Frame Transmitter

This block turns one parallel character at a time into a serial frame on a single transmit line. The frame layout is chosen at run time from the configuration inputs: a character length of five to nine bits, a parity bit that is absent, even or odd, and one or two stop bits. That gives thirty distinct layouts. A frame is a low start bit, the data bits least significant first, the optional parity bit, then the high stop bits. Between frames the line rests high, or a new frame follows the last stop bit with no gap.

Bit timing comes from a one-cycle `baud_tick` enable supplied by an outside divider. In asynchronous mode each bit lasts one tick. In synchronous mode each bit lasts two ticks and the block drives `xclk`. With `clk_pol` = 0 the line data changes on the rising edge of `xclk` and the receiver samples on the falling edge. With `clk_pol` = 1 both edges are swapped. A character is handed over with a valid/ready handshake. The whole format is captured at the moment of handover.

The controller is one state machine with seven states. IDLE waits for a character. ARM holds the line high until the next tick, so the start bit gets a full period. START drives the start bit. DATA shifts out the character. PARITY drives the parity bit. STOP1 and STOP2 drive the stop bits. The transitions are:
- IDLE→ARM on handover.
- ARM→START on a tick.
- START→DATA at the end of the bit.
- DATA→PARITY or DATA→STOP1 after the last data bit.
- PARITY→STOP1.
- STOP1→STOP2 when two stop bits are set.
- From the last stop bit, →START when a new character is handed over on the final tick, otherwise →IDLE.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0, `tx_ready` is 1, and while idle `xclk` equals the live `clk_pol` input.
- R2: A character is accepted on a clock edge where `tx_valid` and `tx_ready` are both 1. From the next cycle `busy` is 1 and `txd` stays 1 until the next `baud_tick`. After that tick `txd` is 0 for one bit period, which is the start bit.
- R3: `data_len` codes 0,1,2,3,4 select 5,6,7,8,9 data bits, and codes 5 to 7 also select 9 bits. The data bits follow the start bit, bit 0 of `tx_data` first and the highest selected bit last.
- R4: `parity_mode` 2'b00 and 2'b01 send no parity bit. 2'b10 (even) and 2'b11 (odd) send one bit right after the last data bit. It makes the number of ones across the selected data bits and the parity bit even or odd respectively.
- R5: `two_stop` = 0 sends one stop bit and `two_stop` = 1 sends two. Every stop bit is 1.
- R6: In asynchronous mode (`sync_mode` = 0) each bit lasts from one `baud_tick` to the next. In synchronous mode each bit lasts two ticks. `txd` holds between those ticks.
- R7: In synchronous mode `xclk` is `~clk_pol` in the first half of every bit and `clk_pol` in the second half. So with polarity 0 the data changes on a rising edge, and with polarity 1 on a falling edge. In asynchronous mode `xclk` stays at `clk_pol`.
- R8: `tx_ready` is 1 only in IDLE, or during the final stop bit in a cycle where `baud_tick` is 1. A character accepted there starts its start bit in the next cycle with no idle gap.
- R9: Format inputs and `tx_data` are captured at acceptance. Changing them during a frame does not alter that frame.
- R10: When the last stop bit ends with no new character, the block returns to IDLE: `txd` is 1, `busy` is 0 and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle bit timing enable |
| sync_mode | input | 1 | 1 selects synchronous mode with `xclk` |
| clk_pol | input | 1 | `xclk` polarity |
| data_len | input | 3 | Character length code (0..4 → 5..9 bits) |
| parity_mode | input | 2 | 00/01 none, 10 even, 11 odd |
| two_stop | input | 1 | 1 selects two stop bits |
| tx_data | input | 9 | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Character can be accepted this cycle |
| txd | output | 1 | Serial transmit line |
| xclk | output | 1 | Synchronous mode clock output |
| busy | output | 1 | A frame is pending or in progress |

## Verification
Every result is due exactly one clock after the edge that causes it, because the state, shift register and half-bit flag are the only registers on each path. `busy` and the held-high line appear one cycle after acceptance. Each new bit and each `xclk` phase appear one cycle after the tick that ends the previous bit or half-bit. `tx_ready` is combinational on `baud_tick` within the final stop bit. The bench raises each tick for a single cycle on a falling edge and samples on the following falling edge, so every value is read half a cycle after the edge that produced it. It checks `tx_ready` while the final tick is still high.

// File: rtl/sft_pkg.sv
package sft_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } tx_state_t;

    typedef enum logic [1:0] {
        PM_NONE = 2'b00,
        PM_RSVD = 2'b01,
        PM_EVEN = 2'b10,
        PM_ODD  = 2'b11
    } par_mode_t;

    typedef struct packed {
        logic par_en;
        logic par_odd;
        logic two_stop;
        logic sync;
        logic pol;
    } fmt_flags_t;

endpackage

// File: rtl/sft_parity.sv
module sft_parity #(
    parameter int DATA_W = 9,
    parameter int CNT_W  = 4
) (
    input  logic [DATA_W-1:0] data,
    input  logic [CNT_W-1:0]  nbits,
    input  logic              odd,
    output logic              parity
);

    logic [DATA_W-1:0] masked;

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign masked[i] = data[i] & (CNT_W'(i) < nbits);
    end

    assign parity = (^masked) ^ odd;

    always_comb begin
        if (!$isunknown({data, nbits, odd})) begin
            assert_parity_count_R4: assert (((($countones(masked) + int'(parity)) % 2) == int'(odd)))
                else $error("parity bit does not give requested ones count");
        end
    end

endmodule

// File: rtl/sft_bit_timer.sv
module sft_bit_timer (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_tick,
    input  logic run,
    input  logic busy,
    input  logic sync_q,
    input  logic pol_q,
    input  logic pol_live,
    output logic bit_end,
    output logic xclk
);

    logic half;

    // Second-half flag: only used in synchronous mode, cleared outside shifting.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half <= 1'b0;
        end else if (!run) begin
            half <= 1'b0;
        end else if (baud_tick && sync_q) begin
            half <= ~half;
        end
    end

    assign bit_end = run & baud_tick & (~sync_q | half);

    always_comb begin
        if (busy) begin
            xclk = pol_q ^ (run & sync_q & ~half);
        end else begin
            xclk = pol_live;
        end
    end

    // R7: after the mid-bit tick the clock sits at its polarity level.
    assert_xclk_second_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sync_q && baud_tick && !half) |=> (xclk == pol_q));

    // R6: in synchronous mode the first tick of a bit never ends the bit.
    assert_sync_two_ticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && sync_q && baud_tick && !half) |=> (run && half));

endmodule

// File: rtl/sft_ctrl.sv
module sft_ctrl
    import sft_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    input  logic [CNT_W-1:0]  nbits_in,
    input  fmt_flags_t        flags_in,
    input  logic              par_in,
    input  logic              baud_tick,
    input  logic              bit_end,
    output logic              tx_ready,
    output logic              txd,
    output logic              busy,
    output logic              run,
    output fmt_flags_t        flags_q
);

    tx_state_t         state, state_nx;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  nbits_q;
    logic [CNT_W-1:0]  cnt;
    logic              par_q;
    logic              accept;
    logic              last_stop;
    logic              last_data;

    assign last_stop = (state == ST_STOP2) || ((state == ST_STOP1) && !flags_q.two_stop);
    assign last_data = (cnt == CNT_W'(nbits_q - 1'b1));
    assign tx_ready  = (state == ST_IDLE) || (last_stop && bit_end);
    assign accept    = tx_valid && tx_ready;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) state_nx = ST_ARM;
            end
            ST_ARM: begin
                if (baud_tick) state_nx = ST_START;
            end
            ST_START: begin
                if (bit_end) state_nx = ST_DATA;
            end
            ST_DATA: begin
                if (bit_end && last_data) begin
                    state_nx = flags_q.par_en ? ST_PARITY : ST_STOP1;
                end
            end
            ST_PARITY: begin
                if (bit_end) state_nx = ST_STOP1;
            end
            ST_STOP1: begin
                if (bit_end) begin
                    if (flags_q.two_stop) state_nx = ST_STOP2;
                    else                  state_nx = accept ? ST_START : ST_IDLE;
                end
            end
            ST_STOP2: begin
                if (bit_end) state_nx = accept ? ST_START : ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Character and format capture, shifting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            nbits_q <= CNT_W'(DATA_W);
            cnt     <= '0;
            par_q   <= 1'b0;
            flags_q <= '0;
        end else if (accept) begin
            shreg   <= tx_data;
            nbits_q <= nbits_in;
            cnt     <= '0;
            par_q   <= par_in;
            flags_q <= flags_in;
        end else if ((state == ST_DATA) && bit_end) begin
            shreg <= shreg >> 1;
            cnt   <= cnt + 1'b1;
        end
    end

    // Output decode
    always_comb begin
        busy = (state != ST_IDLE);
        run  = (state != ST_IDLE) && (state != ST_ARM);
        unique case (state)
            ST_IDLE:   txd = 1'b1;
            ST_ARM:    txd = 1'b1;
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = shreg[0];
            ST_PARITY: txd = par_q;
            ST_STOP1:  txd = 1'b1;
            ST_STOP2:  txd = 1'b1;
            default:   txd = 1'b1;
        endcase
    end

    assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> busy);

    assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARM && baud_tick) |=> (txd == 1'b0));

    assert_ready_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !baud_tick) |-> !tx_ready);

    assert_stop_after_parity_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARITY && bit_end) |=> (txd == 1'b1));

    assert_stop_after_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && bit_end && last_data && !flags_q.par_en) |=> (txd == 1'b1));

    assert_fmt_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !accept) |=> ($stable(flags_q) && $stable(nbits_q)));

    assert_idle_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (last_stop && bit_end && !accept) |=> (txd && !busy));

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
    import sft_pkg::*;
#(
    parameter int DATA_W   = 9,
    parameter int MIN_BITS = 5,
    parameter int LEN_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              sync_mode,
    input  logic              clk_pol,
    input  logic [LEN_W-1:0]  data_len,
    input  logic [1:0]        parity_mode,
    input  logic              two_stop,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              txd,
    output logic              xclk,
    output logic              busy
);

    localparam int CNT_W        = $clog2(DATA_W + 1);
    localparam int LEN_MAX_CODE = DATA_W - MIN_BITS;

    logic [CNT_W-1:0] nbits_in;
    fmt_flags_t       flags_in;
    fmt_flags_t       flags_q;
    logic             par_in;
    logic             bit_end;
    logic             run;
    par_mode_t        pmode;

    assign pmode = par_mode_t'(parity_mode);

    // Length code decode, codes beyond the widest length clamp to it
    always_comb begin
        if (data_len > LEN_W'(LEN_MAX_CODE)) begin
            nbits_in = CNT_W'(DATA_W);
        end else begin
            nbits_in = CNT_W'(MIN_BITS) + CNT_W'(data_len);
        end
    end

    always_comb begin
        flags_in.par_en   = (pmode == PM_EVEN) || (pmode == PM_ODD);
        flags_in.par_odd  = (pmode == PM_ODD);
        flags_in.two_stop = two_stop;
        flags_in.sync     = sync_mode;
        flags_in.pol      = clk_pol;
    end

    sft_parity #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_parity (
        .data   (tx_data),
        .nbits  (nbits_in),
        .odd    (flags_in.par_odd),
        .parity (par_in)
    );

    sft_ctrl #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .nbits_in  (nbits_in),
        .flags_in  (flags_in),
        .par_in    (par_in),
        .baud_tick (baud_tick),
        .bit_end   (bit_end),
        .tx_ready  (tx_ready),
        .txd       (txd),
        .busy      (busy),
        .run       (run),
        .flags_q   (flags_q)
    );

    sft_bit_timer u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .baud_tick (baud_tick),
        .run       (run),
        .busy      (busy),
        .sync_q    (flags_q.sync),
        .pol_q     (flags_q.pol),
        .pol_live  (clk_pol),
        .bit_end   (bit_end),
        .xclk      (xclk)
    );

    assert_idle_xclk_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> (xclk == clk_pol));

endmodule

// File: tb/sim_serial_frame_tx.sv
module sim_serial_frame_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       sync_mode = 1'b0;
    logic       clk_pol = 1'b0;
    logic [2:0] data_len = 3'd3;
    logic [1:0] parity_mode = 2'b00;
    logic       two_stop = 1'b0;
    logic [8:0] tx_data = '0;
    logic       tx_valid = 1'b0;
    logic       tx_ready, txd, xclk, busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic  exp_bits [0:15];
    string exp_tag  [0:15];
    int    exp_n;

    always #4 clk = ~clk;

    serial_frame_tx u0 (
        .clk (clk), .rst_n (rst_n), .baud_tick (baud_tick),
        .sync_mode (sync_mode), .clk_pol (clk_pol), .data_len (data_len),
        .parity_mode (parity_mode), .two_stop (two_stop), .tx_data (tx_data),
        .tx_valid (tx_valid), .tx_ready (tx_ready), .txd (txd),
        .xclk (xclk), .busy (busy)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected frame from the requirements
    task automatic build(input logic [8:0] d, input int lcode, input logic [1:0] pm, input bit two);
        int nb = (lcode > 4) ? 9 : 5 + lcode;
        int ones = 0;
        exp_n = 0;
        exp_bits[exp_n] = 1'b0; exp_tag[exp_n] = "R2 start bit"; exp_n++;
        for (int i = 0; i < nb; i++) begin
            exp_bits[exp_n] = d[i]; exp_tag[exp_n] = "R3 data bit"; exp_n++;
            ones += int'(d[i]);
        end
        if (pm[1]) begin
            exp_bits[exp_n] = pm[0] ? ~ones[0] : ones[0];
            exp_tag[exp_n] = "R4 parity bit"; exp_n++;
        end
        exp_bits[exp_n] = 1'b1; exp_tag[exp_n] = "R5 stop bit"; exp_n++;
        if (two) begin
            exp_bits[exp_n] = 1'b1; exp_tag[exp_n] = "R5 second stop bit"; exp_n++;
        end
    endtask

    task automatic pulse(input bit offer);
        @(negedge clk);
        baud_tick = 1'b1;
        tx_valid  = offer;
        #1;
        if (offer) chk("R8 ready on final stop tick", tx_ready, 1'b1);
        @(negedge clk);
        baud_tick = 1'b0;
        tx_valid  = 1'b0;
    endtask

    task automatic start_frame(input logic [8:0] d, input int lcode, input logic [1:0] pm,
                               input bit two, input bit sy, input bit pol);
        @(negedge clk);
        data_len = 3'(lcode); parity_mode = pm; two_stop = two;
        sync_mode = sy; clk_pol = pol; tx_data = d; tx_valid = 1'b1;
        #1;
        chk("R8 ready while idle", tx_ready, 1'b1);
        @(negedge clk);
        tx_valid = 1'b0;
        chk("R2 busy after accept", busy, 1'b1);
        chk("R2 line high before first tick", txd, 1'b1);
        chk("R8 ready low while armed", tx_ready, 1'b0);
        build(d, lcode, pm, two);
        pulse(1'b0);
    endtask

    task automatic shift_check(input bit sy, input bit pol, input bit chain, input logic [8:0] nxt);
        for (int i = 0; i < exp_n; i++) begin
            chk(exp_tag[i], txd, exp_bits[i]);
            if (sy) begin
                chk("R7 xclk first half", xclk, ~pol);
                pulse(1'b0);
                chk("R6 line holds over half tick", txd, exp_bits[i]);
                chk("R7 xclk second half", xclk, pol);
            end else begin
                chk("R7 xclk steady in async", xclk, pol);
                if (i == 1) begin
                    repeat (3) @(negedge clk);
                    chk("R6 line holds without tick", txd, exp_bits[i]);
                    chk("R8 ready low mid frame", tx_ready, 1'b0);
                end
            end
            if (chain && i == exp_n - 1) begin
                tx_data = nxt;
                pulse(1'b1);
            end else begin
                pulse(1'b0);
            end
        end
    endtask

    task automatic end_check();
        chk("R10 idle line high", txd, 1'b1);
        chk("R10 busy low", busy, 1'b0);
        chk("R10 ready high", tx_ready, 1'b1);
    endtask

    task automatic test_reset();
        clk_pol = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset txd", txd, 1'b1);
        chk("R1 reset busy", busy, 1'b0);
        chk("R1 reset ready", tx_ready, 1'b1);
        chk("R1 idle xclk follows pol=1", xclk, 1'b1);
        clk_pol = 1'b0;
        #1;
        chk("R1 idle xclk follows pol=0", xclk, 1'b0);
    endtask

    task automatic test_async_formats();
        start_frame(9'h0A5, 3, 2'b00, 1'b0, 1'b0, 1'b0); shift_check(1'b0, 1'b0, 1'b0, '0); end_check();
        start_frame(9'h013, 0, 2'b10, 1'b1, 1'b0, 1'b0); shift_check(1'b0, 1'b0, 1'b0, '0); end_check();
        start_frame(9'h02C, 1, 2'b11, 1'b0, 1'b0, 1'b1); shift_check(1'b0, 1'b1, 1'b0, '0); end_check();
        start_frame(9'h155, 4, 2'b11, 1'b1, 1'b0, 1'b0); shift_check(1'b0, 1'b0, 1'b0, '0); end_check();
        start_frame(9'h07F, 2, 2'b01, 1'b0, 1'b0, 1'b0); shift_check(1'b0, 1'b0, 1'b0, '0); end_check();
    endtask

    task automatic test_len_clamp();
        start_frame(9'h1C3, 7, 2'b10, 1'b0, 1'b0, 1'b0); shift_check(1'b0, 1'b0, 1'b0, '0); end_check();
    endtask

    task automatic test_sync();
        start_frame(9'h0B6, 3, 2'b10, 1'b0, 1'b1, 1'b0); shift_check(1'b1, 1'b0, 1'b0, '0); end_check();
        chk("R7 idle xclk pol 0", xclk, 1'b0);
        start_frame(9'h1E1, 4, 2'b11, 1'b1, 1'b1, 1'b1); shift_check(1'b1, 1'b1, 1'b0, '0); end_check();
        chk("R7 idle xclk pol 1", xclk, 1'b1);
    endtask

    task automatic test_b2b();
        start_frame(9'h016, 0, 2'b00, 1'b0, 1'b0, 1'b0);
        shift_check(1'b0, 1'b0, 1'b1, 9'h009);
        chk("R8 next start bit with no gap", txd, 1'b0);
        chk("R8 busy stays high", busy, 1'b1);
        build(9'h009, 0, 2'b00, 1'b0);
        shift_check(1'b0, 1'b0, 1'b0, '0);
        end_check();
        start_frame(9'h133, 4, 2'b10, 1'b1, 1'b1, 1'b0);
        shift_check(1'b1, 1'b0, 1'b1, 9'h0CC);
        chk("R8 sync next start bit with no gap", txd, 1'b0);
        build(9'h0CC, 4, 2'b10, 1'b1);
        shift_check(1'b1, 1'b0, 1'b0, '0);
        end_check();
    endtask

    task automatic test_cfg_change();
        start_frame(9'h0F0, 3, 2'b11, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        data_len = 3'd0; parity_mode = 2'b00; two_stop = 1'b0; tx_data = 9'h1FF;
        // R9: the frame must follow the captured format and character
        shift_check(1'b0, 1'b0, 1'b0, '0);
        end_check();
    endtask

    initial begin
        test_reset();
        test_async_formats();
        test_len_clamp();
        test_sync();
        test_b2b();
        test_cfg_change();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule